// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block gathers up to eight interrupt request lines and presents at most one interrupt at a time to a processor. Each line sets a bit in a request register when it carries a one-cycle pulse. Among the requests that are pending and not masked, the lowest-numbered line wins. It is granted only if no line of equal or higher priority is still in service. A grant moves the line from the request register to the in-service register and raises `int_valid`. At the same time it presents a vector made of a programmable base plus the line index. The outputs hold steady until `int_ack` is seen.

Software reaches the block through a byte-wide port with one address bit. Writes to the command address (`bus_addr`=0) are sorted by two bits of the byte into three kinds: initialization start, read-select and end-of-interrupt. Writes to the data address (`bus_addr`=1) are steered by a small sequencer. After a start word they load the vector base and then a cascade word, which is ignored. An optional fourth word follows, which sets automatic end-of-interrupt. Any later data write loads the mask. `cascade_out` is raised with a grant of line 2, so that a downstream controller can be chained there.

Top module: `irq_ctl8`

## Requirements
- R1: After reset the mask reads 0xFF (all lines disabled), the request and in-service registers are zero, a command-address read returns the request register, and `int_valid` is low.
- R2: When the sequencer is idle and no fourth word is pending, a data-address write loads the mask, and a data-address read returns it exactly as written. A line whose mask bit is 1 is never granted.
- R3: A pulse on a masked line sets its request bit, which stays pending and readable. The line is granted once its mask bit is cleared.
- R4: A command write with bit 4 set is a start word. The next data write loads the vector base. The data write after that is a cascade word that changes nothing, and the sequencer then returns to idle.
- R5: If bit 0 of the start word was 1, the first data write after the cascade word is the fourth word. Its bit 1 sets automatic end-of-interrupt, and it leaves the mask unchanged.
- R6: A command write with bit 4 clear and bit 3 set selects what a command read returns: bit 0 = 1 gives the request register, and bit 0 = 0 gives the in-service register.
- R7: The grant candidate is the lowest-numbered line that is both pending and unmasked.
- R8: On a grant, the line's request bit clears and its in-service bit sets. One clock later `int_valid` rises with `int_vector` = base + line index (modulo 256). Both outputs stay constant until a cycle with `int_ack` high, after which `int_valid` falls.
- R9: The candidate is withheld while any in-service bit of the same or a lower index is set. A set bit of a higher index does not block it.
- R10: A command write with bits 4 and 3 clear and bits 7:5 = 011 clears the in-service bit whose index is in bits 2:0. Codes other than 011 and 001 leave the in-service register unchanged.
- R11: A command write with bits 4 and 3 clear and bits 7:5 = 001 clears only the lowest-numbered set in-service bit.
- R12: With automatic end-of-interrupt set, the granted line's in-service bit is cleared in the acknowledge cycle.
- R13: `cascade_out` is high together with `int_valid` when line 2 is the granted line, and low for any other line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pulse | input | 8 | One-cycle request pulse per line |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = command address, 1 = data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from registers) |
| int_valid | output | 1 | An interrupt grant is presented |
| int_vector | output | 8 | Vector of the presented grant |
| int_ack | input | 1 | Acknowledge of the presented grant |
| cascade_out | output | 1 | Presented grant is line 2 |

## Verification
Several request patterns are driven. Two lines pulsed together show whether the lower index wins. A higher-index pulse while a lower index is in service must wait, while a lower-index pulse in the same situation is granted at once; this separates the window check from a check on any in-service bit. A repeat pulse on a line still in service shows that equal priority also blocks. A pulse on a masked line shows that a pending request differs from a granted one. The end-of-interrupt codes are tried with two lines in service, so that the specific, lowest-bit and ignored codes each leave a different in-service value. Initialization is run both with and without the fourth word, and then with automatic end-of-interrupt, where a repeated request on the same line must be granted again.

// File: rtl/irq_ctl8_pkg.sv
package irq_ctl8_pkg;

  // data-address write sequencer
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_CASC = 2'd2
  } seq_t;

  // command byte decoding positions and codes
  localparam int unsigned START_BIT = 4;
  localparam int unsigned RSEL_BIT  = 3;
  localparam logic [2:0]  EOI_SPEC  = 3'b011;
  localparam logic [2:0]  EOI_LOW   = 3'b001;

endpackage

// File: rtl/irq_ctl8_cfg.sv
module irq_ctl8_cfg
  import irq_ctl8_pkg::*;
#(
  parameter int unsigned NL = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  input  logic [NL-1:0] isr,
  output logic [DW-1:0] base,
  output logic [NL-1:0] mask,
  output logic          read_sel,
  output logic          auto_eoi,
  output logic [NL-1:0] eoi_clr
);
  localparam int unsigned IW = $clog2(NL);

  function automatic logic [NL-1:0] lowest_of(input logic [NL-1:0] v);
    return v & (~v + NL'(1));
  endfunction

  function automatic logic [NL-1:0] line_bit(input logic [IW-1:0] i);
    return NL'(1) << i;
  endfunction

  seq_t seq;
  logic fourth_due;

  logic cmd_wr, dat_wr, is_start, is_rsel, is_eoi;
  logic [2:0] eoi_code;

  assign cmd_wr   = wr & ~addr;
  assign dat_wr   = wr & addr;
  assign is_start = cmd_wr & wdata[START_BIT];
  assign is_rsel  = cmd_wr & ~wdata[START_BIT] & wdata[RSEL_BIT];
  assign is_eoi   = cmd_wr & ~wdata[START_BIT] & ~wdata[RSEL_BIT];
  assign eoi_code = wdata[DW-1:DW-3];

  always_comb begin
    eoi_clr = '0;
    if (is_eoi) begin
      if (eoi_code == EOI_SPEC)     eoi_clr = line_bit(wdata[IW-1:0]);
      else if (eoi_code == EOI_LOW) eoi_clr = lowest_of(isr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq        <= SEQ_IDLE;
      fourth_due <= 1'b0;
      auto_eoi   <= 1'b0;
      base       <= '0;
      mask       <= '1;
      read_sel   <= 1'b1;
    end else begin
      if (is_start) begin
        fourth_due <= wdata[0];
        seq        <= SEQ_BASE;
      end
      if (is_rsel) read_sel <= wdata[0];
      if (dat_wr) begin
        case (seq)
          SEQ_BASE: begin
            base <= wdata;
            seq  <= SEQ_CASC;
          end
          SEQ_CASC: seq <= SEQ_IDLE;
          default: begin
            if (fourth_due) begin
              auto_eoi   <= wdata[1];
              fourth_due <= 1'b0;
            end else begin
              mask <= wdata[NL-1:0];
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_ctl8_arb.sv
module irq_ctl8_arb #(
  parameter int unsigned NL = 8
) (
  input  logic [NL-1:0]         irr,
  input  logic [NL-1:0]         isr,
  input  logic [NL-1:0]         mask,
  output logic                  found,
  output logic                  blocked,
  output logic [NL-1:0]         cand_oh,
  output logic [$clog2(NL)-1:0] cand_idx
);
  localparam int unsigned IW = $clog2(NL);

  function automatic logic [NL-1:0] lowest_of(input logic [NL-1:0] v);
    return v & (~v + NL'(1));
  endfunction

  // the line itself and every line of higher priority
  function automatic logic [NL-1:0] prio_window(input logic [NL-1:0] oh);
    return oh | (oh - NL'(1));
  endfunction

  function automatic logic [IW-1:0] index_of(input logic [NL-1:0] oh);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < NL; i++)
      if (oh[i]) r = IW'(i);
    return r;
  endfunction

  logic [NL-1:0] enabled;

  assign enabled  = irr & ~mask;
  assign found    = |enabled;
  assign cand_oh  = lowest_of(enabled);
  assign cand_idx = index_of(cand_oh);
  assign blocked  = |(isr & prio_window(cand_oh));
endmodule

// File: rtl/irq_ctl8_core.sv
module irq_ctl8_core #(
  parameter int unsigned NL   = 8,
  parameter int unsigned DW   = 8,
  parameter int unsigned CASC = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NL-1:0]         irq_pulse,
  input  logic                  grant_fire,
  input  logic [NL-1:0]         cand_oh,
  input  logic [$clog2(NL)-1:0] cand_idx,
  input  logic [DW-1:0]         base,
  input  logic [NL-1:0]         eoi_clr,
  input  logic                  auto_eoi,
  input  logic                  int_ack,
  output logic [NL-1:0]         irr,
  output logic [NL-1:0]         isr,
  output logic                  int_valid,
  output logic [DW-1:0]         int_vector,
  output logic                  cascade_out
);
  localparam int unsigned IW = $clog2(NL);

  function automatic logic [DW-1:0] vector_of(input logic [DW-1:0] b, input logic [IW-1:0] i);
    return b + DW'(i);
  endfunction

  logic [NL-1:0] cur_oh;
  logic [NL-1:0] grant_set, auto_clr;
  logic          ack_fire;

  assign grant_set = grant_fire ? cand_oh : '0;
  assign ack_fire  = int_valid & int_ack;
  assign auto_clr  = (ack_fire & auto_eoi) ? cur_oh : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr         <= '0;
      isr         <= '0;
      cur_oh      <= '0;
      int_valid   <= 1'b0;
      int_vector  <= '0;
      cascade_out <= 1'b0;
    end else begin
      irr <= (irr & ~grant_set) | irq_pulse;
      isr <= (isr & ~eoi_clr & ~auto_clr) | grant_set;
      if (grant_fire) begin
        int_valid   <= 1'b1;
        int_vector  <= vector_of(base, cand_idx);
        cascade_out <= cand_oh[CASC];
        cur_oh      <= cand_oh;
      end else if (ack_fire) begin
        int_valid   <= 1'b0;
        cascade_out <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_ctl8.sv
module irq_ctl8 #(
  parameter int unsigned NL   = 8,
  parameter int unsigned DW   = 8,
  parameter int unsigned CASC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] irq_pulse,
  input  logic          bus_wr,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          int_valid,
  output logic [DW-1:0] int_vector,
  input  logic          int_ack,
  output logic          cascade_out
);
  localparam int unsigned IW = $clog2(NL);

  logic [DW-1:0] base;
  logic [NL-1:0] mask, irr, isr, eoi_clr, cand_oh, grant_oh;
  logic [IW-1:0] cand_idx;
  logic          read_sel, auto_eoi, found, blocked, grant_fire;

  irq_ctl8_cfg #(.NL(NL), .DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .isr(isr), .base(base), .mask(mask), .read_sel(read_sel),
    .auto_eoi(auto_eoi), .eoi_clr(eoi_clr)
  );

  irq_ctl8_arb #(.NL(NL)) u_arb (
    .irr(irr), .isr(isr), .mask(mask), .found(found), .blocked(blocked),
    .cand_oh(cand_oh), .cand_idx(cand_idx)
  );

  // one grant outstanding at a time
  assign grant_fire = found & ~blocked & ~int_valid;
  assign grant_oh   = grant_fire ? cand_oh : '0;

  irq_ctl8_core #(.NL(NL), .DW(DW), .CASC(CASC)) u_core (
    .clk(clk), .rst_n(rst_n), .irq_pulse(irq_pulse), .grant_fire(grant_fire),
    .cand_oh(cand_oh), .cand_idx(cand_idx), .base(base), .eoi_clr(eoi_clr),
    .auto_eoi(auto_eoi), .int_ack(int_ack), .irr(irr), .isr(isr),
    .int_valid(int_valid), .int_vector(int_vector), .cascade_out(cascade_out)
  );

  assign bus_rdata = bus_addr ? DW'(mask) : (read_sel ? DW'(irr) : DW'(isr));
endmodule

// File: rtl/irq_ctl8_chk.sv
module irq_ctl8_chk #(
  parameter int unsigned NL   = 8,
  parameter int unsigned DW   = 8,
  parameter int unsigned CASC = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NL-1:0] irq_pulse,
  input logic          int_valid,
  input logic [DW-1:0] int_vector,
  input logic          int_ack,
  input logic          cascade_out,
  input logic [NL-1:0] irr,
  input logic [NL-1:0] isr,
  input logic [NL-1:0] mask,
  input logic [DW-1:0] base,
  input logic          grant_fire,
  input logic [NL-1:0] grant_oh
);
  localparam logic [NL-1:0] ONE = NL'(1);

  function automatic logic [DW-1:0] idx_val(input logic [NL-1:0] oh);
    logic [DW-1:0] r;
    r = '0;
    for (int i = 0; i < NL; i++)
      if (oh[i]) r = DW'(i);
    return r;
  endfunction

  p_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |-> ((grant_oh & mask) == '0));

  p_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |-> ((irr & ~mask & (grant_oh - ONE)) == '0));

  p_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_fire && ((irq_pulse & grant_oh) == '0)) |=>
      (((irr & $past(grant_oh)) == '0) && ((isr & $past(grant_oh)) != '0)));

  p_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |=> (int_valid && int_vector == $past(base) + idx_val($past(grant_oh))));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int_valid && !int_ack) |=> (int_valid && $stable(int_vector) && $stable(cascade_out)));

  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int_valid && int_ack) |=> !int_valid);

  p_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |-> ((isr & (grant_oh | (grant_oh - ONE))) == '0));

  p_cascade_r13: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |=> (cascade_out == $past(grant_oh[CASC])));
endmodule

bind irq_ctl8 irq_ctl8_chk #(.NL(NL), .DW(DW), .CASC(CASC)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_pulse(irq_pulse), .int_valid(int_valid),
  .int_vector(int_vector), .int_ack(int_ack), .cascade_out(cascade_out),
  .irr(irr), .isr(isr), .mask(mask), .base(base),
  .grant_fire(grant_fire), .grant_oh(grant_oh)
);

// File: tb/irq_ctl8_bench.sv
module irq_ctl8_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_pulse = '0;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       int_valid;
  logic [7:0] int_vector;
  logic       int_ack = 1'b0;
  logic       cascade_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [8:0] sb[$];   // {cascade, vector}

  always #4 clk = ~clk;

  irq_ctl8 u_irq_ctl8 (
    .clk(clk), .rst_n(rst_n), .irq_pulse(irq_pulse), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .int_valid(int_valid), .int_vector(int_vector), .int_ack(int_ack),
    .cascade_out(cascade_out)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, input logic [7:0] exp, input string req);
    bus_addr = a;
    #1;
    check(req, {1'b0, bus_rdata}, {1'b0, exp});
  endtask

  task automatic pulse(input logic [7:0] lines);
    @(negedge clk);
    irq_pulse = lines;
    @(negedge clk);
    irq_pulse = '0;
  endtask

  // expected grant: vector = base + line, cascade when line 2
  task automatic expect_grant(input logic [7:0] b, input int line);
    sb.push_back({line == 2, b + 8'(line)});
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (sb.size() != 0 || int_valid || int_ack);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_quiet(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req, {8'h0, int_valid}, 9'h0);
    end
  endtask

  // monitor: compare each presented grant, hold two cycles, then acknowledge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && int_valid) begin
        logic [8:0] got;
        got = {cascade_out, int_vector};
        if (sb.size() == 0) begin
          check("R8 unexpected grant", got, 9'h1FF);
        end else begin
          logic [8:0] want;
          want = sb.pop_front();
          check("R8/R13 grant", got, want);
          repeat (2) @(negedge clk);
          check("R8 hold", {int_valid, int_vector}, {1'b1, want[7:0]});
        end
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    bus_read(1'b1, 8'hFF, "R1 mask");
    bus_read(1'b0, 8'h00, "R1 request");
    check("R1 valid", {8'h0, int_valid}, 9'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4/R5 init with fourth word, auto-EOI off
    bus_write(1'b0, 8'h11);
    bus_write(1'b1, 8'h40);
    bus_write(1'b1, 8'hAA);
    bus_read(1'b1, 8'hFF, "R4 cascade word ignored");
    bus_write(1'b1, 8'h00);
    bus_read(1'b1, 8'hFF, "R5 fourth word leaves mask");
    bus_write(1'b1, 8'hF0);
    bus_read(1'b1, 8'hF0, "R2 mask readback");

    // R3 masked line stays pending
    pulse(8'h20);
    check_quiet(4, "R3 masked not granted");
    bus_read(1'b0, 8'h20, "R3 pending request");

    // R7 priority, R9 blocking by lower index
    expect_grant(8'h40, 1);
    pulse(8'h0A);
    wait_idle();
    check_quiet(3, "R9 higher index waits");
    bus_read(1'b0, 8'h28, "R9 request still pending");
    bus_write(1'b0, 8'h08);
    bus_read(1'b0, 8'h02, "R6 in-service select");

    // R10 specific EOI releases line 3
    expect_grant(8'h40, 3);
    bus_write(1'b0, 8'h61);
    wait_idle();
    bus_read(1'b0, 8'h08, "R10 specific EOI");
    bus_write(1'b0, 8'h40);
    bus_write(1'b0, 8'hA0);
    bus_read(1'b0, 8'h08, "R10 other codes ignored");

    // R9 lower index preempts a higher one in service
    expect_grant(8'h40, 0);
    pulse(8'h01);
    wait_idle();
    bus_read(1'b0, 8'h09, "R9 lower index granted");

    // R11 non-specific EOI clears lowest bit only
    bus_write(1'b0, 8'h20);
    bus_read(1'b0, 8'h08, "R11 lowest cleared");
    bus_write(1'b0, 8'h20);
    bus_read(1'b0, 8'h00, "R11 next cleared");

    // R9 equal index blocked
    expect_grant(8'h40, 0);
    pulse(8'h01);
    wait_idle();
    pulse(8'h01);
    check_quiet(3, "R9 equal index waits");
    bus_write(1'b0, 8'h09);
    bus_read(1'b0, 8'h21, "R6 request select");
    expect_grant(8'h40, 0);
    bus_write(1'b0, 8'h20);
    wait_idle();
    bus_write(1'b0, 8'h20);
    bus_write(1'b0, 8'h08);
    bus_read(1'b0, 8'h00, "R11 all clear");

    // R13 cascade on line 2
    expect_grant(8'h40, 2);
    pulse(8'h04);
    wait_idle();
    bus_write(1'b0, 8'h20);

    // R3 unmask releases pending line 5
    expect_grant(8'h40, 5);
    bus_write(1'b1, 8'h00);
    wait_idle();
    bus_read(1'b0, 8'h20, "R3 granted after unmask");
    bus_write(1'b0, 8'h20);

    // R12 auto-EOI
    bus_write(1'b0, 8'h11);
    bus_write(1'b1, 8'h80);
    bus_write(1'b1, 8'h5A);
    bus_read(1'b1, 8'h00, "R4 cascade word ignored again");
    bus_write(1'b1, 8'h02);
    bus_read(1'b1, 8'h00, "R5 fourth word leaves mask");
    expect_grant(8'h80, 4);
    pulse(8'h10);
    wait_idle();
    bus_read(1'b0, 8'h00, "R12 cleared on ack");
    expect_grant(8'h80, 4);
    pulse(8'h10);
    wait_idle();
    bus_read(1'b0, 8'h00, "R12 regranted and cleared");

    // R4 init without fourth word: third data write is a mask
    bus_write(1'b0, 8'h10);
    bus_write(1'b1, 8'h20);
    bus_write(1'b1, 8'h33);
    bus_write(1'b1, 8'h55);
    bus_read(1'b1, 8'h55, "R4 no fourth word");
    expect_grant(8'h20, 1);
    pulse(8'h03);
    wait_idle();
    bus_read(1'b0, 8'h00, "R2 masked line 0 not granted");
    bus_write(1'b0, 8'h09);
    bus_read(1'b0, 8'h01, "R2 masked line 0 pending");

    check("R8 scoreboard empty", 9'(sb.size()), 9'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule